// File: doc/BRIEF.md
# Write Leveling Strobe Delay Search

This block calibrates the launch delay of one data strobe against the memory clock during write leveling. Board routing that chains the clock past several devices reaches each device at a different time. Each strobe therefore needs its own delay setting, and one instance of this block serves one strobe.

When started, the block asks the mode register sequencer to put the memory into leveling mode. It then walks a tap-delay code upward from zero. After each code change it waits a fixed settle time. It then emits a burst of strobe pulses and takes the 1-bit feedback that the memory returns for each pulse, reducing the burst to a single bit by majority vote. The search locks on the first tap whose vote is 1 after some earlier tap has voted 0. That tap is where the strobe edge has moved past the clock rising edge, and holding it keeps the strobe-to-clock skew within limits. If the top tap is reached with no such transition, the block flags an error. In both cases it then asks the sequencer to take the memory out of leveling mode and reports completion.

The mode register request is a valid/ready channel. Once `mr_valid` is raised it stays high, with `mr_level_on` unchanged, until a cycle in which `mr_ready` is also high. That cycle completes the transfer. The sequencer may hold off by keeping `mr_ready` low for any number of cycles, and the search does not move while it waits.

Top module: `wl_dqs_level`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `error`, `dqs_pulse`, `mr_valid`, `mr_level_on` are 0 and `dqs_delay` is 0.
- R2: A `start` pulse while idle clears `done`, `error` and `dqs_delay` and raises `mr_valid` with `mr_level_on`=1 in the next cycle. `mr_valid` and `mr_level_on` hold until the cycle in which `mr_ready` is high. A `start` while `busy` is 1 has no effect on the search or its result.
- R3: After leveling entry is accepted, and after every change of `dqs_delay`, `dqs_pulse` stays low for at least SETTLE_CYC cycles before the next sample burst.
- R4: Each tap is evaluated by NUM_SAMPLES consecutive cycles with `dqs_pulse` high. `fb_in` is sampled in each of those cycles and `dqs_delay` does not change during them. The tap votes 1 when more than half of the samples are 1.
- R5: The search locks on the first tap whose vote is 1 after an earlier tap has voted 0, and `dqs_delay` keeps that tap after completion.
- R6: A tap that votes 1 before any tap has voted 0 does not lock, and the search moves on to the next tap.
- R7: If the top tap (all ones) is evaluated without locking, `error` is set and `dqs_delay` returns to 0.
- R8: After lock or failure, `mr_valid` rises with `mr_level_on`=0. In the cycle after that request is accepted, `busy` falls and `done` rises. `done` and `error` stay unchanged until the next accepted `start`.
- R9: While `busy` is 1, `dqs_delay` only changes by +1 or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (honoured only when idle) |
| busy | output | 1 | Search or mode register exchange in progress |
| done | output | 1 | Last search finished |
| error | output | 1 | Last search found no 0-to-1 transition |
| dqs_delay | output | TAP_W | Tap code for the strobe delay line |
| dqs_pulse | output | 1 | Strobe pulse request, one per feedback sample |
| fb_in | input | 1 | Clock level fed back by the memory |
| mr_valid | output | 1 | Mode register request valid |
| mr_ready | input | 1 | Mode register request accepted |
| mr_level_on | output | 1 | Request payload: 1 enter leveling, 0 leave |

## Verification
The bench builds the block with TAP_W=4, SETTLE_CYC=3 and NUM_SAMPLES=3. With these values every tap, including the top tap and the full-range failures, is reached in a few hundred cycles. Because three samples are taken per tap, the bench can flip exactly one sample in every burst and show that the vote masks it. The feedback is a per-tap table, so patterns that start high, have a late high region or never go high each drive the search down a different path. A behavioural model is compared against the outputs on every cycle under varied ready latency.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    WL_IDLE,
    WL_MR_ON,
    WL_SETTLE,
    WL_SAMPLE,
    WL_MR_OFF
  } wl_state_e;
endpackage

// File: rtl/wl_delay_ctr.sv
module wl_delay_ctr #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [TAP_W-1:0] code,
  output logic             at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code <= '0;
    else if (clr) code <= '0;
    else if (inc) code <= code + 1'b1;
  end

  assign at_max = &code;
endmodule

// File: rtl/wl_vote.sv
module wl_vote #(
  parameter int NUM_SAMPLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic fb,
  output logic vote_now
);
  localparam int ONES_W = $clog2(NUM_SAMPLES + 1);

  logic [ONES_W-1:0] ones;
  logic [ONES_W:0]   sum;

  // running count including the sample taken this cycle
  assign sum      = {1'b0, ones} + {{ONES_W{1'b0}}, fb};
  assign vote_now = {sum, 1'b0} > (ONES_W + 2)'(NUM_SAMPLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ones <= '0;
    else if (clr) ones <= '0;
    else if (en)  ones <= sum[ONES_W-1:0];
  end
endmodule

// File: rtl/wl_edge_det.sv
module wl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic eval,
  input  logic vote,
  output logic lock_now
);
  logic seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen_low <= 1'b0;
    else if (clr)            seen_low <= 1'b0;
    else if (eval && !vote)  seen_low <= 1'b1;
  end

  assign lock_now = eval && vote && seen_low;
endmodule

// File: rtl/wl_dqs_level.sv
module wl_dqs_level
  import wl_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int SETTLE_CYC  = 8,
  parameter int NUM_SAMPLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [TAP_W-1:0] dqs_delay,
  output logic             dqs_pulse,
  input  logic             fb_in,
  output logic             mr_valid,
  input  logic             mr_ready,
  output logic             mr_level_on
);
  localparam int CNT_MAX     = (SETTLE_CYC > NUM_SAMPLES) ? SETTLE_CYC : NUM_SAMPLES;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(NUM_SAMPLES - 1);

  wl_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             go, eval, vote_now, lock_now, at_max;
  logic             fail_now, step_now;

  assign go       = (state == WL_IDLE) && start;
  assign eval     = (state == WL_SAMPLE) && (cnt == SAMPLE_LAST);
  assign fail_now = eval && !lock_now && at_max;
  assign step_now = eval && !lock_now && !at_max;

  wl_delay_ctr #(.TAP_W(TAP_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr(go || fail_now), .inc(step_now),
    .code(dqs_delay), .at_max(at_max)
  );

  wl_vote #(.NUM_SAMPLES(NUM_SAMPLES)) u_vote (
    .clk(clk), .rst_n(rst_n),
    .clr(state == WL_SETTLE), .en(state == WL_SAMPLE),
    .fb(fb_in), .vote_now(vote_now)
  );

  wl_edge_det u_edge (
    .clk(clk), .rst_n(rst_n),
    .clr(go), .eval(eval), .vote(vote_now),
    .lock_now(lock_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WL_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      unique case (state)
        WL_IDLE: if (start) begin
          state <= WL_MR_ON;
          done  <= 1'b0;
          error <= 1'b0;
        end
        WL_MR_ON: if (mr_ready) begin
          state <= WL_SETTLE;
          cnt   <= '0;
        end
        WL_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            state <= WL_SAMPLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WL_SAMPLE: begin
          if (eval) begin
            cnt <= '0;
            if (lock_now) begin
              state <= WL_MR_OFF;
            end else if (at_max) begin
              state <= WL_MR_OFF;
              error <= 1'b1;
            end else begin
              state <= WL_SETTLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WL_MR_OFF: if (mr_ready) begin
          state <= WL_IDLE;
          done  <= 1'b1;
        end
        default: state <= WL_IDLE;
      endcase
    end
  end

  assign busy        = (state != WL_IDLE);
  assign dqs_pulse   = (state == WL_SAMPLE);
  assign mr_valid    = (state == WL_MR_ON) || (state == WL_MR_OFF);
  assign mr_level_on = (state == WL_MR_ON);
endmodule

// File: rtl/wl_checker.sv
module wl_checker #(
  parameter int TAP_W       = 5,
  parameter int SETTLE_CYC  = 8,
  parameter int NUM_SAMPLES = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [TAP_W-1:0] dqs_delay,
  input logic             dqs_pulse,
  input logic             mr_valid,
  input logic             mr_ready,
  input logic             mr_level_on
);
  localparam int RUN_W = $clog2(SETTLE_CYC + 1);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  low_run <= '0;
    else if (dqs_pulse)                          low_run <= '0;
    else if (low_run < RUN_W'(SETTLE_CYC))       low_run <= low_run + 1'b1;
  end

  // R2
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid && !mr_ready |=> mr_valid && $stable(mr_level_on));

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_pulse) |-> low_run >= RUN_W'(SETTLE_CYC));

  // R4
  burst_tap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse && $past(dqs_pulse) |-> $stable(dqs_delay));

  // R7
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error && !busy |-> done && dqs_delay == '0);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mr_valid && !dqs_pulse);

  // R9
  tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (dqs_delay != $past(dqs_delay)) |->
      (dqs_delay == $past(dqs_delay) + 1'b1) || (dqs_delay == '0));
endmodule

bind wl_dqs_level wl_checker #(
  .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .NUM_SAMPLES(NUM_SAMPLES)
) u_wl_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .dqs_delay(dqs_delay), .dqs_pulse(dqs_pulse), .mr_valid(mr_valid),
  .mr_ready(mr_ready), .mr_level_on(mr_level_on)
);

// File: tb/test_wl_dqs_level.sv
module test_wl_dqs_level;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 4;
  localparam int SET = 3;
  localparam int NS  = 3;
  localparam int MAXTAP = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, dqs_pulse, mr_valid, mr_level_on;
  logic [TW-1:0] dqs_delay;
  logic fb_in;
  logic mr_ready = 1'b0;

  logic [15:0] pat = 16'h0;
  bit noisy = 1'b0;
  int pcnt = 0;
  int rdy_lat = 0;
  int hcnt = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wl_dqs_level #(.TAP_W(TW), .SETTLE_CYC(SET), .NUM_SAMPLES(NS)) i_wl_dqs_level (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .dqs_delay(dqs_delay), .dqs_pulse(dqs_pulse),
    .fb_in(fb_in), .mr_valid(mr_valid), .mr_ready(mr_ready),
    .mr_level_on(mr_level_on)
  );

  // memory feedback: per-tap table, optionally first sample of each burst flipped
  always_comb fb_in = pat[dqs_delay] ^ (noisy && (pcnt == 0));

  always @(posedge clk) if (dqs_pulse) pcnt <= (pcnt == NS - 1) ? 0 : pcnt + 1;

  // sequencer side of the request channel
  always @(negedge clk) begin
    if (mr_ready) begin
      mr_ready = 1'b0;
      hcnt = 0;
    end else if (mr_valid) begin
      if (hcnt >= rdy_lat) mr_ready = 1'b1;
      else hcnt++;
    end else hcnt = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 entering, 2 settling, 3 sampling, 4 leaving
  int ph, mcode, mcnt, mones, mdone, merr;
  bit mlow;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mcode = 0; mcnt = 0; mones = 0; mdone = 0; merr = 0; mlow = 0;
    end else begin
      case (ph)
        0: if (start) begin ph = 1; mcode = 0; mdone = 0; merr = 0; mlow = 0; end
        1: if (mr_ready) begin ph = 2; mcnt = 0; end
        2: if (mcnt == SET - 1) begin ph = 3; mcnt = 0; mones = 0; end else mcnt++;
        3: begin
          mones += int'(fb_in);
          if (mcnt == NS - 1) begin
            mcnt = 0;
            if (2 * mones > NS && mlow) ph = 4;
            else begin
              if (2 * mones <= NS) mlow = 1;
              if (mcode == MAXTAP) begin merr = 1; mcode = 0; ph = 4; end
              else begin mcode++; ph = 2; end
            end
          end else mcnt++;
        end
        4: if (mr_ready) begin ph = 0; mdone = 1; end
        default: ph = 0;
      endcase
    end
  end

  // per-cycle comparison plus port-level rule checks
  int prev_delay = 0;
  int lowrun = 0;
  bit prev_pulse = 0;
  bit in_reset = 1;
  always @(negedge clk) begin
    if (!in_reset) begin
      check(int'(dqs_delay) == mcode, "R5 delay", int'(dqs_delay), mcode);
      check(dqs_pulse == (ph == 3), "R4 pulse", int'(dqs_pulse), int'(ph == 3));
      check(mr_valid == (ph == 1 || ph == 4), "R2 valid", int'(mr_valid), int'(ph == 1 || ph == 4));
      check(mr_level_on == (ph == 1), "R8 level_on", int'(mr_level_on), int'(ph == 1));
      check(busy == (ph != 0), "R2 busy", int'(busy), int'(ph != 0));
      check(done == mdone[0], "R8 done", int'(done), mdone);
      check(error == merr[0], "R7 error", int'(error), merr);
      if (busy && int'(dqs_delay) != prev_delay)
        check(int'(dqs_delay) == prev_delay + 1 || dqs_delay == 0, "R9 step",
              int'(dqs_delay), prev_delay + 1);
      if (dqs_pulse && !prev_pulse)
        check(lowrun >= SET, "R3 settle", lowrun, SET);
    end
    lowrun = dqs_pulse ? 0 : lowrun + 1;
    prev_pulse = dqs_pulse;
    prev_delay = int'(dqs_delay);
  end

  task automatic run(input logic [15:0] p, input bit nz, input int lat, input int mid,
                     input int exp_code, input int exp_err, input string req);
    int cyc;
    @(negedge clk);
    pat = p; noisy = nz; pcnt = 0; rdy_lat = lat;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (mid != 0 && cyc == mid);
    end
    start = 1'b0;
    check(done == 1'b1, {req, " done"}, int'(done), 1);
    check(int'(dqs_delay) == exp_code, {req, " code"}, int'(dqs_delay), exp_code);
    check(int'(error) == exp_err, {req, " error"}, int'(error), exp_err);
    repeat (3) @(negedge clk);
    // R8: results hold while idle
    check(int'(dqs_delay) == exp_code && done, "R8 hold", int'(dqs_delay), exp_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !error && !dqs_pulse && !mr_valid && !mr_level_on && dqs_delay == 0,
          "R1 reset", int'({busy, done, error, dqs_pulse, mr_valid, mr_level_on}), 0);
    rst_n = 1'b1;
    in_reset = 0;
    @(negedge clk);
    check(!busy && dqs_delay == 0, "R1 after release", int'(busy), 0);
    run(16'hFFE0, 1'b0, 0, 0,  5, 0, "R5 clean");
    run(16'hFFE0, 1'b1, 2, 0,  5, 0, "R4 noisy");
    run(16'hFF87, 1'b0, 1, 0,  7, 0, "R6 early high");
    run(16'h0000, 1'b0, 0, 0,  0, 1, "R7 never high");
    run(16'hFFFF, 1'b0, 3, 0,  0, 1, "R6 always high");
    run(16'h8000, 1'b1, 0, 0, 15, 0, "R5 top tap");
    run(16'hFE00, 1'b0, 4, 12, 9, 0, "R2 start ignored");
    run(16'h00F0, 1'b0, 0, 0,  4, 0, "R5 late fall");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule